// File: doc/BRIEF.md
# Windowed Banked Register File

This block is a register file split into several windows of eight registers each. Instruction operand fields are only three bits wide. A small window-select field, kept in the machine status word, sits above those three bits to form the physical register number. Ordinary reads and writes can therefore reach only the active window. The compiler spreads its variables over all windows and moves between them with two extra operations. A window swap changes which window is active. A cross-window move copies a register of the active window into any physical register, without changing the active window.

The file has two combinational read ports and one ordinary write port. Swaps and moves are separate command inputs. A parameter selects a build with two windows (16 registers) or four windows (32 registers). The swap command always carries a three-bit window number, so a number outside the built range can be detected and refused. The active-window value is brought out so that it can be saved and restored along with the rest of the status word.

Top module: `winreg_file`

## Requirements
- R1: After reset the active window is 0, the error flag is 0, and every physical register reads 0.
- R2: The physical register addressed by a 3-bit operand is {active window, operand}; for example, operand 1 in window 1 is physical register 9. Both read ports are combinational.
- R3: When `wr_en` is high, `wr_data` is stored at the rising edge into {active window, `wr_idx`}. A read of that register in the next cycle returns the new value.
- R4: A swap with a window number below NUM_WIN sets the active window at the rising edge. All later operands decode against the new window.
- R5: A write issued in the same cycle as a swap goes to the window that was active before the swap.
- R6: A swap to the window that is already active changes nothing and raises no error.
- R7: A swap with a window number at or above NUM_WIN leaves the active window unchanged. It sets `swap_err` high for exactly the one cycle after the command.
- R8: A move copies register {active window, `mv_src_idx`} into physical register `mv_dst` at the rising edge and leaves the active window unchanged.
- R9: When a move and a write target the same physical register in one cycle, the moved value is stored. A move reads its source before any write of that cycle, so it copies the old value.
- R10: Ordinary writes never change registers of a window other than the active one.
- R11: `active_win` always shows the current active-window value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 3 | Read port A operand |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 3 | Read port B operand |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Ordinary write enable |
| wr_idx | input | 3 | Ordinary write operand |
| wr_data | input | DATA_W | Ordinary write data |
| swap_en | input | 1 | Window swap command |
| swap_win | input | 3 | Requested window number |
| mv_en | input | 1 | Cross-window move command |
| mv_src_idx | input | 3 | Move source operand in the active window |
| mv_dst | input | log2(NUM_WIN)+3 | Move destination physical register |
| active_win | output | log2(NUM_WIN) | Current active window |
| swap_err | output | 1 | Refused swap flag, one cycle |

## Verification
The same 3-bit operand is written and read in different windows. This shows that the window bits really extend the index and that windows are isolated, rather than the file acting as one shared bank of eight. Swaps are tried to a new window, to the current window and to numbers 4 and 5, which separates a valid change, a no-op and a refused request. A write in the same cycle as a swap shows which window the write uses. Moves are checked alone, then colliding with a write on the destination, then with a write on their source, which fixes both the order of precedence and the read-before-write rule.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
    localparam int OPND_W = 3;   // operand field width
    localparam int SWAP_W = 3;   // width of swap window number
    localparam int WIN_REGS = 1 << OPND_W;
endpackage

// File: rtl/winreg_idx.sv
module winreg_idx #(
    parameter int WIN_W = 2
) (
    input  logic [WIN_W-1:0]                      win,
    input  logic [winreg_pkg::OPND_W-1:0]         opnd,
    output logic [WIN_W+winreg_pkg::OPND_W-1:0]   phys
);
    always_comb phys = {win, opnd};
endmodule

// File: rtl/winreg_ctl.sv
module winreg_ctl #(
    parameter int NUM_WIN = 4,
    localparam int WIN_W = $clog2(NUM_WIN)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          swap_en,
    input  logic [winreg_pkg::SWAP_W-1:0] swap_win,
    output logic [WIN_W-1:0]              win_q_o,
    output logic                          err_o
);
    import winreg_pkg::*;
    localparam logic [SWAP_W-1:0] WIN_LIMIT = SWAP_W'(NUM_WIN);

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic             err;
    } ctl_t;

    ctl_t st_d, st_q;
    logic in_range;

    always_comb begin
        in_range = (swap_win < WIN_LIMIT);
        st_d     = st_q;
        st_d.err = 1'b0;
        if (swap_en) begin
            if (in_range) st_d.win = swap_win[WIN_W-1:0];
            else          st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win_q_o = st_q.win;
    assign err_o   = st_q.err;

    AST_SWAP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        swap_en && (swap_win < WIN_LIMIT) |=> (win_q_o == $past(swap_win[WIN_W-1:0])) && !err_o); // R4
    AST_SWAP_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        swap_en && (swap_win >= WIN_LIMIT) |=> $stable(win_q_o) && err_o); // R7
    AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_en |=> $stable(win_q_o) && !err_o); // R4
endmodule

// File: rtl/winreg_bank.sv
module winreg_bank #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 16,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_phys,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_phys,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic [IDX_W-1:0]  mv_src_phys,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_phys,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mv_en,
    input  logic [IDX_W-1:0]  mv_dst
);
    logic [DATA_W-1:0] regs_d [NUM_REGS];
    logic [DATA_W-1:0] regs_q [NUM_REGS];
    logic [DATA_W-1:0] mv_val;

    always_comb begin
        mv_val    = regs_q[mv_src_phys];
        rd_a_data = regs_q[rd_a_phys];
        rd_b_data = regs_q[rd_b_phys];
        for (int i = 0; i < NUM_REGS; i++) regs_d[i] = regs_q[i];
        if (wr_en) regs_d[wr_phys] = wr_data;
        if (mv_en) regs_d[mv_dst]  = mv_val;   // move overrides write on collision
    end

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) regs_q[g] <= '0;
                else        regs_q[g] <= regs_d[g];
            end
        end
    endgenerate

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !(mv_en && (mv_dst == wr_phys)) |=> regs_q[$past(wr_phys)] == $past(wr_data)); // R3
    AST_MOVE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        mv_en |=> regs_q[$past(mv_dst)] == $past(regs_q[mv_src_phys])); // R9
endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
    parameter int NUM_WIN = 4,
    parameter int DATA_W  = 16,
    localparam int WIN_W    = $clog2(NUM_WIN),
    localparam int PHYS_W   = WIN_W + winreg_pkg::OPND_W,
    localparam int NUM_REGS = NUM_WIN * winreg_pkg::WIN_REGS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [winreg_pkg::OPND_W-1:0] rd_a_idx,
    output logic [DATA_W-1:0]             rd_a_data,
    input  logic [winreg_pkg::OPND_W-1:0] rd_b_idx,
    output logic [DATA_W-1:0]             rd_b_data,
    input  logic                          wr_en,
    input  logic [winreg_pkg::OPND_W-1:0] wr_idx,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          swap_en,
    input  logic [winreg_pkg::SWAP_W-1:0] swap_win,
    input  logic                          mv_en,
    input  logic [winreg_pkg::OPND_W-1:0] mv_src_idx,
    input  logic [PHYS_W-1:0]             mv_dst,
    output logic [WIN_W-1:0]              active_win,
    output logic                          swap_err
);
    import winreg_pkg::*;
    localparam int N_OPND = 4;   // read A, read B, write, move source

    logic [WIN_W-1:0]  win_q;
    logic [OPND_W-1:0] opnd [N_OPND];
    logic [PHYS_W-1:0] phys [N_OPND];

    always_comb begin
        opnd[0] = rd_a_idx;
        opnd[1] = rd_b_idx;
        opnd[2] = wr_idx;
        opnd[3] = mv_src_idx;
    end

    generate
        for (genvar g = 0; g < N_OPND; g++) begin : g_idx
            winreg_idx #(.WIN_W(WIN_W)) u_idx (
                .win  (win_q),
                .opnd (opnd[g]),
                .phys (phys[g])
            );
        end
    endgenerate

    winreg_ctl #(.NUM_WIN(NUM_WIN)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .swap_en  (swap_en),
        .swap_win (swap_win),
        .win_q_o  (win_q),
        .err_o    (swap_err)
    );

    winreg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_a_phys   (phys[0]),
        .rd_a_data   (rd_a_data),
        .rd_b_phys   (phys[1]),
        .rd_b_data   (rd_b_data),
        .mv_src_phys (phys[3]),
        .wr_en       (wr_en),
        .wr_phys     (phys[2]),
        .wr_data     (wr_data),
        .mv_en       (mv_en),
        .mv_dst      (mv_dst)
    );

    assign active_win = win_q;

    AST_MOVE_KEEPS_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        mv_en && !swap_en |=> $stable(active_win)); // R8
    AST_SAME_WIN_NOERR: assert property (@(posedge clk) disable iff (!rst_n)
        swap_en && (swap_win == 3'(active_win)) |=> $stable(active_win) && !swap_err); // R6
endmodule

// File: tb/winreg_file_tb.sv
module winreg_file_tb;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0, mv_src_idx = '0, swap_win = '0;
    logic [DATA_W-1:0] rd_a_data, rd_b_data, wr_data = '0;
    logic              wr_en = 1'b0, swap_en = 1'b0, mv_en = 1'b0;
    logic [4:0]        mv_dst = '0;
    logic [1:0]        active_win;
    logic              swap_err;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    winreg_file #(.NUM_WIN(4), .DATA_W(DATA_W)) u_dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
        wr_en = 0; swap_en = 0; mv_en = 0;
    endtask

    task automatic wr(input logic [2:0] i, input logic [DATA_W-1:0] d);
        wr_en = 1; wr_idx = i; wr_data = d; step();
    endtask

    task automatic swap(input logic [2:0] w);
        swap_en = 1; swap_win = w; step();
    endtask

    task automatic rd_a(input logic [2:0] i, input logic [DATA_W-1:0] exp, input string tag);
        rd_a_idx = i; #0.5; chk(tag, rd_a_data, exp);
    endtask

    task automatic t_reset();
        chk("R1 win", active_win, 0);
        chk("R1 err", swap_err, 0);
        rd_a(3'd5, 16'h0, "R1 reg");
    endtask

    task automatic t_write();
        wr(3'd1, 16'h1111);
        rd_a(3'd1, 16'h1111, "R3 readback");
        rd_b_idx = 3'd2; #0.5; chk("R2 port b other reg", rd_b_data, 16'h0);
        rd_b_idx = 3'd1; #0.5; chk("R2 port b same reg", rd_b_data, 16'h1111);
    endtask

    task automatic t_swap();
        swap(3'd1);
        chk("R11 win1", active_win, 1);
        rd_a(3'd1, 16'h0, "R4 phys9 empty");
        wr(3'd1, 16'h2222);
        rd_a(3'd1, 16'h2222, "R2 phys9");
        swap(3'd0);
        rd_a(3'd1, 16'h1111, "R10 window0 kept");
        swap(3'd1);
        rd_a(3'd1, 16'h2222, "R4 back to window1");
    endtask

    task automatic t_swap_same();
        swap(3'd1);
        chk("R6 win", active_win, 1);
        chk("R6 err", swap_err, 0);
        rd_a(3'd1, 16'h2222, "R6 data");
    endtask

    task automatic t_bad_swap();
        swap(3'd5);
        chk("R7 err set", swap_err, 1);
        chk("R7 win kept", active_win, 1);
        step();
        chk("R7 err one cycle", swap_err, 0);
        swap(3'd4);
        chk("R7 err at limit", swap_err, 1);
        chk("R7 win at limit", active_win, 1);
        step();
    endtask

    task automatic t_swap_write();
        wr_en = 1; wr_idx = 3'd3; wr_data = 16'h3333;
        swap_en = 1; swap_win = 3'd2; step();
        chk("R11 win2", active_win, 2);
        rd_a(3'd3, 16'h0, "R5 not in new window");
        swap(3'd1);
        rd_a(3'd3, 16'h3333, "R5 in old window");
    endtask

    task automatic t_move();
        mv_en = 1; mv_src_idx = 3'd1; mv_dst = 5'd30; step();
        chk("R8 win kept", active_win, 1);
        swap(3'd3);
        rd_a(3'd6, 16'h2222, "R8 copied");
    endtask

    task automatic t_move_conflict();
        wr_en = 1; wr_idx = 3'd2; wr_data = 16'hAAAA;
        mv_en = 1; mv_src_idx = 3'd6; mv_dst = 5'd26; step();
        rd_a(3'd2, 16'h2222, "R9 move wins");
        wr_en = 1; wr_idx = 3'd6; wr_data = 16'h5555;
        mv_en = 1; mv_src_idx = 3'd6; mv_dst = 5'd0; step();
        rd_a(3'd6, 16'h5555, "R9 source written");
        swap(3'd0);
        rd_a(3'd0, 16'h2222, "R9 old source copied");
        rd_a(3'd1, 16'h1111, "R10 window0 r1 intact");
    endtask

    initial begin
        #12; rst_n = 1; #1;
        t_reset();
        t_write();
        t_swap();
        t_swap_same();
        t_bad_swap();
        t_swap_write();
        t_move();
        t_move_conflict();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin repeat (5000) @(posedge clk); end
        join_any
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule